// File: doc/BRIEF.md
# Timer-IRQ Board Bank Controller

This block sits behind a serial register loader on a cartridge-style board. The loader hands it finished register values with a one-cycle write strobe for each. It turns them into two 16 KB program bank numbers, one for the lower half of the program window and one for the upper half, and an interrupt line driven by a free-running cycle timer. Character memory is fixed RAM and is not handled here.

The value written to the loader's character-bank slot is not used as a character bank. It is held as a board control word. Bit 3 selects the addressing mode. When it is 0, the whole window maps one 32 KB bank chosen by bits 2:1. When it is 1, the ordinary 16 KB layout logic is used, but it is confined to the upper 128 KB. Bit 4 controls the timer: while it is held at 1 the timer is stopped, and writing a word with bit 4 set clears both the count and any pending interrupt.

The timer counts one per clock while enabled. It fires when the count, ORed with the DIP-switch value shifted into the bits just below the counter's top bit, reaches a threshold whose five top bits are ones. When it fires, the count goes back to zero and the interrupt line goes high and stays high.

Top module: `tirq_board`

## Requirements
- R1: After reset the control word is 0, the layout field is 3, the bank field is 0, `irqOut` is 0, `bankLo` is 0 and `bankHi` is 1.
- R2: With control bit 3 at 0, `bankLo` = 2*w and `bankHi` = 2*w+1, where w is control bits 2:1. The layout and bank fields have no effect.
- R3: With control bit 3 at 1 and layout 3, `bankLo` = 8+b and `bankHi` = 15, where b is the 3-bit bank field.
- R4: With control bit 3 at 1 and layout 2, `bankLo` = 8 and `bankHi` = 8+b.
- R5: With control bit 3 at 1 and layout 0 or 1, `bankLo` = 8+(b AND 6) and `bankHi` = 8+(b AND 6)+1.
- R6: Every register write is reflected on the bank outputs directly after the clock edge that takes the strobe.
- R7: While the latched control bit 4 is 0, the timer advances once per clock. `irqOut` rises after the n-th counted edge, where n is the smallest n ≥ 1 such that (n OR (dip << (CNT_W-5))) ≥ 31 << (CNT_W-5).
- R8: Once raised, `irqOut` stays at 1 until a control word with bit 4 set is written, even while the timer keeps running.
- R9: A control word write with bit 4 set drops `irqOut` and clears the count on that edge. While bit 4 stays latched, the timer does not advance and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| layoutWe | input | 1 | Write strobe for the layout field |
| layoutSel | input | 2 | Layout field (0/1 paired, 2 low fixed, 3 high fixed) |
| bankWe | input | 1 | Write strobe for the bank field |
| bankSel | input | 3 | Low three bits of the 16 KB bank value |
| boardWe | input | 1 | Write strobe for the control word |
| boardWord | input | 4 | Control word bits 4:1 (bit 0 has no function) |
| dipSw | input | DIP_W | DIP-switch threshold value |
| bankLo | output | BANK_W | 16 KB bank for the lower window half |
| bankHi | output | BANK_W | 16 KB bank for the upper window half |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bank mapping is driven through every control word, layout and bank field combination. This separates the 32 KB path, where the layout and bank fields must have no effect, from each of the three 16 KB layouts. The timer runs once for every DIP value, on a narrow counter. Each run measures the edge count to the first interrupt and compares it with the threshold formula, so a wrong shift, a wrong comparison or an off-by-one in counting shows as a different period. Separate runs check that the interrupt stays high after it fires, and that a latched bit 4 stops the timer for longer than any period.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // strobes from the control side to the timer datapath
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } tmrStrb_t;

  typedef enum logic [1:0] {
    LAY_PAIR0 = 2'b00,
    LAY_PAIR1 = 2'b01,
    LAY_LOFIX = 2'b10,
    LAY_HIFIX = 2'b11
  } layout_e;
endpackage

// File: rtl/tirq_ctrl.sv
module tirq_ctrl
  import tirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       layoutWe,
  input  logic [1:0] layoutSel,
  input  logic       bankWe,
  input  logic [2:0] bankSel,
  input  logic       boardWe,
  input  logic [4:1] boardWord,
  output layout_e    layoutReg,
  output logic [2:0] bankReg,
  output logic [4:1] boardReg,
  output tmrStrb_t   strb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      layoutReg <= LAY_HIFIX;
      bankReg   <= '0;
      boardReg  <= '0;
    end else begin
      if (layoutWe) layoutReg <= layout_e'(layoutSel);
      if (bankWe)   bankReg   <= bankSel;
      if (boardWe)  boardReg  <= boardWord;
    end
  end

  always_comb begin
    strb.clrCnt = boardWe & boardWord[4];
    strb.cntEn  = ~boardReg[4];
  end

  // R6
  board_latch_chk: assert property (@(posedge clk) disable iff (rst)
    boardWe |=> boardReg == $past(boardWord));
  // R6
  bank_latch_chk: assert property (@(posedge clk) disable iff (rst)
    bankWe |=> bankReg == $past(bankSel));
endmodule

// File: rtl/tirq_timer.sv
module tirq_timer
  import tirq_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int DIP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrb_t         strb,
  input  logic [DIP_W-1:0] dipSw,
  output logic             irqOut
);
  localparam int TOP_BITS = 5;
  localparam int SHIFT    = CNT_W - TOP_BITS;
  localparam logic [CNT_W:0] THRESH =
    {{(CNT_W+1-TOP_BITS){1'b0}}, {TOP_BITS{1'b1}}} << SHIFT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cntInc;
  logic [CNT_W:0]   dipExt;
  logic             hit;

  assign cntInc = {1'b0, cnt} + 1'b1;
  assign dipExt = {{(CNT_W+1-DIP_W){1'b0}}, dipSw} << SHIFT;
  assign hit    = (cntInc | dipExt) >= THRESH;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      irqOut <= 1'b0;
    end else if (strb.clrCnt) begin
      cnt    <= '0;
      irqOut <= 1'b0;
    end else if (strb.cntEn) begin
      if (hit) begin
        cnt    <= '0;
        irqOut <= 1'b1;
      end else begin
        cnt <= cntInc[CNT_W-1:0];
      end
    end
  end

  // R7
  irq_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(strb.cntEn));
  // R9
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clrCnt |=> !irqOut && cnt == '0);
  // R9
  frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.cntEn && !strb.clrCnt) |=> $stable(cnt) && $stable(irqOut));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irqOut && !strb.clrCnt) |=> irqOut);
endmodule

// File: rtl/tirq_bankmap.sv
module tirq_bankmap
  import tirq_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  layout_e           layoutReg,
  input  logic [2:0]        bankReg,
  input  logic [3:1]        boardSel,
  output logic [BANK_W-1:0] bankLo,
  output logic [BANK_W-1:0] bankHi
);
  localparam logic [BANK_W-1:0] UPPER = BANK_W'(8);

  logic [BANK_W-1:0] bankVal;
  logic [BANK_W-1:0] pairBase;

  assign bankVal  = UPPER | BANK_W'(bankReg);
  assign pairBase = UPPER | BANK_W'({bankReg[2:1], 1'b0});

  always_comb begin
    if (!boardSel[3]) begin
      bankLo = BANK_W'({boardSel[2:1], 1'b0});
      bankHi = BANK_W'({boardSel[2:1], 1'b1});
    end else begin
      unique case (layoutReg)
        LAY_HIFIX: begin
          bankLo = bankVal;
          bankHi = UPPER | BANK_W'(7);
        end
        LAY_LOFIX: begin
          bankLo = UPPER;
          bankHi = bankVal;
        end
        default: begin
          bankLo = pairBase;
          bankHi = pairBase | BANK_W'(1);
        end
      endcase
    end
  end

  // R2
  wide_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !boardSel[3] |-> (bankHi == bankLo + 1'b1) && !bankLo[0]);
  // R3
  upper_region_chk: assert property (@(posedge clk) disable iff (rst)
    boardSel[3] |-> bankLo[3] && bankHi[3]);
endmodule

// File: rtl/tirq_board.sv
module tirq_board
  import tirq_pkg::*;
#(
  parameter int CNT_W  = 30,
  parameter int DIP_W  = 4,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              layoutWe,
  input  logic [1:0]        layoutSel,
  input  logic              bankWe,
  input  logic [2:0]        bankSel,
  input  logic              boardWe,
  input  logic [4:1]        boardWord,
  input  logic [DIP_W-1:0]  dipSw,
  output logic [BANK_W-1:0] bankLo,
  output logic [BANK_W-1:0] bankHi,
  output logic              irqOut
);
  layout_e    layoutReg;
  logic [2:0] bankReg;
  logic [4:1] boardReg;
  tmrStrb_t   strb;

  tirq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .layoutWe(layoutWe), .layoutSel(layoutSel),
    .bankWe(bankWe), .bankSel(bankSel),
    .boardWe(boardWe), .boardWord(boardWord),
    .layoutReg(layoutReg), .bankReg(bankReg), .boardReg(boardReg),
    .strb(strb)
  );

  tirq_timer #(.CNT_W(CNT_W), .DIP_W(DIP_W)) u_timer (
    .clk(clk), .rst(rst), .strb(strb), .dipSw(dipSw), .irqOut(irqOut)
  );

  tirq_bankmap #(.BANK_W(BANK_W)) u_map (
    .clk(clk), .rst(rst),
    .layoutReg(layoutReg), .bankReg(bankReg), .boardSel(boardReg[3:1]),
    .bankLo(bankLo), .bankHi(bankHi)
  );
endmodule

// File: tb/tirq_board_bench.sv
`timescale 1ns/1ps
module tirq_board_bench;
  localparam int CNT_W = 8;
  localparam int SHIFT = CNT_W - 5;
  localparam int THR   = 31 << SHIFT;

  logic clk = 0, rst = 1;
  logic layoutWe = 0, bankWe = 0, boardWe = 0;
  logic [1:0] layoutSel = 0;
  logic [2:0] bankSel = 0;
  logic [4:1] boardWord = 0;
  logic [3:0] dipSw = 4'hE;
  logic [3:0] bankLo, bankHi;
  logic irqOut;
  int nCmp = 0, nBad = 0;

  always #2.5 clk = ~clk;

  tirq_board #(.CNT_W(CNT_W)) u_tirq_board (
    .clk(clk), .rst(rst), .layoutWe(layoutWe), .layoutSel(layoutSel),
    .bankWe(bankWe), .bankSel(bankSel), .boardWe(boardWe),
    .boardWord(boardWord), .dipSw(dipSw),
    .bankLo(bankLo), .bankHi(bankHi), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrBoard(input int v);
    @(negedge clk); boardWe = 1; boardWord = 4'((v >> 1) & 15);
    @(posedge clk); #1 boardWe = 0;
  endtask
  task automatic wrLayout(input int v);
    @(negedge clk); layoutWe = 1; layoutSel = 2'(v);
    @(posedge clk); #1 layoutWe = 0;
  endtask
  task automatic wrBank(input int v);
    @(negedge clk); bankWe = 1; bankSel = 3'(v);
    @(posedge clk); #1 bankWe = 0;
  endtask

  function automatic int firstHit(input int dip);
    for (int n = 1; n < 1024; n++)
      if ((n | (dip << SHIFT)) >= THR) return n;
    return -1;
  endfunction

  task automatic expBanks(input int w, input int lay, input int b,
                          output int lo, output int hi);
    if (((w >> 3) & 1) == 0) begin
      lo = ((w >> 1) & 3) * 2; hi = lo + 1;
    end else if (lay == 3) begin
      lo = 8 + b; hi = 15;
    end else if (lay == 2) begin
      lo = 8; hi = 8 + b;
    end else begin
      lo = 8 + (b & 6); hi = lo + 1;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int lo, hi, k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #0.5;
    // R1 reset state
    chk("R1 bankLo", int'(bankLo), 0);
    chk("R1 bankHi", int'(bankHi), 1);
    chk("R1 irq", int'(irqOut), 0);

    // R1 layout 3 and bank 0 after reset: enter 16 KB mode only
    wrBoard(8);
    chk("R1 layout reset lo", int'(bankLo), 8);
    chk("R1 layout reset hi", int'(bankHi), 15);

    // R2 R3 R4 R5 R6 full sweep
    for (int lay = 0; lay < 4; lay++) begin
      wrLayout(lay);
      for (int b = 0; b < 8; b++) begin
        wrBank(b);
        for (int w = 0; w < 32; w += 2) begin
          wrBoard(w);
          expBanks(w, lay, b, lo, hi);
          chk(((w & 8) != 0) ? (lay == 3 ? "R3 lo" : lay == 2 ? "R4 lo" : "R5 lo")
                             : "R2 lo", int'(bankLo), lo);
          chk("R6 hi", int'(bankHi), hi);
        end
      end
    end

    // R7 period for every DIP value
    for (int d = 0; d < 16; d++) begin
      wrBoard(16);
      chk("R9 ack clears irq", int'(irqOut), 0);
      dipSw = 4'(d);
      wrBoard(0);
      k = 0;
      while (!irqOut && k < 600) begin
        @(posedge clk); #1 k++;
      end
      chk("R7 cycles to irq", k, firstHit(d));
      // R8 level held while timer keeps running
      repeat (40) @(posedge clk);
      #1 chk("R8 irq held", int'(irqOut), 1);
    end

    // R9 frozen timer never fires
    wrBoard(16);
    chk("R9 irq dropped", int'(irqOut), 0);
    repeat (600) @(posedge clk);
    #1 chk("R9 frozen no irq", int'(irqOut), 0);
    // R9 count was cleared: restart gives a full period
    dipSw = 4'hF;
    wrBoard(0);
    k = 0;
    while (!irqOut && k < 600) begin
      @(posedge clk); #1 k++;
    end
    chk("R9 restart period", k, firstHit(15));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule